// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers a parameterised number of interrupt request lines (64 by default, in banks of 32) and drives two processor-side request pins. One is a normal-priority request (`irq_o`) and the other is a fast request (`fiq_o`). Every source line has two complete routes, one toward each output. Each route has its own pending latch, enable, trigger-mode select and polarity select. A line can therefore feed neither output, one of them, or both, and it can use a different detection style on each route.

Every input first passes through a two-flop synchroniser. Level-mode routes track the synchronised line continuously. Edge-mode routes latch an event until software clears it. Software sees the block through a 32-bit, APB-style register port: `psel`, `penable`, `pwrite`, `paddr`, `pwdata` and `prdata`. A write completes in the access phase, with `psel` and `penable` both high. Read data is combinational whenever `psel` is high. The port has no wait states, so it never back-pressures. The request inputs are plain levels and have no handshake.

The register space is split into register sets. Set `s` belongs to bank `s/2` and is the fast route when `s` is odd. Its base address is `(s/2)*0x60 + (s%2)*0x20`, which gives 0x00, 0x20, 0x60 and 0x80 by default. Sources 0–31 are bank 0 and sources 32–63 are bank 1. Within a set, the word offsets are:

| Offset | Register | Access |
|---|---|---|
| 0x00 | pending | read-only |
| 0x04 | enable | read/write |
| 0x08 | clear | write-only, reads 0 |
| 0x0C | mode | read/write |
| 0x10 | polarity | read/write |
| 0x14 | masked status | read-only |

Top module: `dual_route_intc`

## Requirements
- R1: While reset is asserted, and after it is released, every register and the stored input history are zero and both `irq_o` and `fiq_o` are low.
- R2: The register sets sit at the bases given above, with the word offsets given above. Writes to the pending or status word leave them unchanged.
- R3: The enable, mode and polarity words of every set read back the last 32-bit value written to them.
- R4: When a route's mode bit is 0 (level), its pending bit equals the synchronised input when the polarity bit is 0 (active-high), and the inverted input when the polarity bit is 1 (active-low).
- R5: When a route's mode bit is 1 (edge), its pending bit is set by a 0-to-1 change of the synchronised input if the polarity bit is 0, or by a 1-to-0 change if it is 1. The bit then stays set after the input returns.
- R6: Writing a word to a clear register zeroes only those pending bits that are both 1 in the written word and in edge mode. Level-mode pending bits are unaffected.
- R7: Reading a status word returns that set's pending word ANDed with its enable word.
- R8: `irq_o` is the OR of all enabled pending bits in the even-numbered sets. `fiq_o` is the same for the odd-numbered sets. The two routes of one source act independently.
- R9: Reads at any address above 0x94 return zero, and writes there change no register.
- R10: A change on a source line first affects its pending bit and the outputs at the third rising clock edge after the change, not earlier.
- R11: If an edge event and a clear of the same bit take effect in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt request lines, asynchronous |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high |
| irq_o | output | 1 | Normal request output |
| fiq_o | output | 1 | Fast request output |

## Verification
The hardest case to reach is an edge event and a software clear landing on the same pending bit in the same clock. To get there, the bench first latches an edge, then drops the line. It then raises the line and starts the clear write exactly one cycle later, so that the write's commit edge coincides with the third synchroniser edge. The other hard case is the gap between synchroniser latency and pending latency. The bench checks the outputs on the second and third falling edges after a line change, to pin down the exact delay. A one-hot sweep over all 64 lines exercises every bit position in both banks.

// File: rtl/dual_route_intc_pkg.sv
package dual_route_intc_pkg;

  localparam int SET_W = 32;

  typedef enum logic [2:0] {
    SUB_PEND = 3'd0,
    SUB_EN   = 3'd1,
    SUB_CLR  = 3'd2,
    SUB_MODE = 3'd3,
    SUB_POL  = 3'd4,
    SUB_STAT = 3'd5
  } sub_reg_e;

  function automatic int set_base(input int s);
    return (s / 2) * 'h60 + (s % 2) * 'h20;
  endfunction

endpackage

// File: rtl/dri_sync.sv
module dri_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dri_route_set.sv
module dri_route_set #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp,
  input  logic [W-1:0] prev,
  input  logic         wr_en,
  input  logic         wr_mode,
  input  logic         wr_pol,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] mode,
  output logic [W-1:0] pol
);
  logic [W-1:0] rise, fall, evt, clr_mask, lvl_val, pend_nxt;

  always_comb begin
    rise     = samp & ~prev;
    fall     = prev & ~samp;
    evt      = (pol & fall) | (~pol & rise);
    clr_mask = wr_clr ? (wdata & mode) : '0;
    lvl_val  = samp ^ pol;
    // edge bits: event wins over clear; level bits: follow input
    pend_nxt = (mode & (evt | (pend & ~clr_mask))) | (~mode & lvl_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      mode <= '0;
      pol  <= '0;
    end else begin
      pend <= pend_nxt;
      if (wr_en)   en   <= wdata;
      if (wr_mode) mode <= wdata;
      if (wr_pol)  pol  <= wdata;
    end
  end
endmodule

// File: rtl/dual_route_intc.sv
module dual_route_intc
  import dual_route_intc_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NUM_BANKS = NUM_SRC / SET_W;
  localparam int NUM_SETS  = 2 * NUM_BANKS;
  localparam int LAST_ADDR = set_base(NUM_SETS - 1) + 'h14;

  logic [NUM_SRC-1:0] samp, prev_q;
  logic [SET_W-1:0]   pend [NUM_SETS];
  logic [SET_W-1:0]   en   [NUM_SETS];
  logic [SET_W-1:0]   mode [NUM_SETS];
  logic [SET_W-1:0]   pol  [NUM_SETS];
  logic [SET_W-1:0]   stat [NUM_SETS];
  logic [SET_W-1:0]   rd_word [NUM_SETS];
  logic [NUM_SETS-1:0] set_hit;
  logic [NUM_SETS*SET_W-1:0] pend_flat, en_flat, mode_flat;

  logic     in_range, wr_acc;
  sub_reg_e sub;

  assign in_range = (int'(paddr) <= LAST_ADDR);
  assign wr_acc   = psel && penable && pwrite && in_range;
  assign sub      = sub_reg_e'(paddr[4:2]);

  dri_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_i), .q(samp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= samp;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int BANK = s / 2;
    localparam logic [ADDR_W-6:0] BLK = (ADDR_W-5)'(set_base(s) >> 5);

    assign set_hit[s] = in_range && (paddr[ADDR_W-1:5] == BLK);

    dri_route_set #(.W(SET_W)) u_set (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp   (samp[BANK*SET_W +: SET_W]),
      .prev   (prev_q[BANK*SET_W +: SET_W]),
      .wr_en  (wr_acc && set_hit[s] && sub == SUB_EN),
      .wr_mode(wr_acc && set_hit[s] && sub == SUB_MODE),
      .wr_pol (wr_acc && set_hit[s] && sub == SUB_POL),
      .wr_clr (wr_acc && set_hit[s] && sub == SUB_CLR),
      .wdata  (pwdata),
      .pend   (pend[s]),
      .en     (en[s]),
      .mode   (mode[s]),
      .pol    (pol[s])
    );

    assign stat[s] = pend[s] & en[s];
    assign pend_flat[s*SET_W +: SET_W] = pend[s];
    assign en_flat[s*SET_W +: SET_W]   = en[s];
    assign mode_flat[s*SET_W +: SET_W] = mode[s];

    always_comb begin
      case (sub)
        SUB_PEND: rd_word[s] = pend[s];
        SUB_EN:   rd_word[s] = en[s];
        SUB_MODE: rd_word[s] = mode[s];
        SUB_POL:  rd_word[s] = pol[s];
        SUB_STAT: rd_word[s] = stat[s];
        default:  rd_word[s] = '0;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    for (int s = 0; s < NUM_SETS; s++)
      if (psel && set_hit[s]) prdata = prdata | rd_word[s];
  end

  always_comb begin
    irq_o = 1'b0;
    fiq_o = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (s % 2 == 0) irq_o = irq_o | (|stat[s]);
      else            fiq_o = fiq_o | (|stat[s]);
    end
  end
endmodule

// File: rtl/dri_chk.sv
module dri_chk #(
  parameter int NUM_SETS = 4,
  parameter int ADDR_W   = 12,
  parameter int LAST     = 'h94
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [ADDR_W-1:0]      paddr,
  input logic [31:0]            pwdata,
  input logic [31:0]            prdata,
  input logic                   irq_o,
  input logic                   fiq_o,
  input logic [NUM_SETS*32-1:0] pend_flat,
  input logic [NUM_SETS*32-1:0] en_flat,
  input logic [NUM_SETS*32-1:0] mode_flat
);
  logic [31:0] p0, e0, m0;
  logic        clr0, wen0;
  assign p0   = pend_flat[31:0];
  assign e0   = en_flat[31:0];
  assign m0   = mode_flat[31:0];
  assign clr0 = psel && penable && pwrite && paddr == ADDR_W'('h08);
  assign wen0 = psel && penable && pwrite && paddr == ADDR_W'('h04);

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!irq_o && !fiq_o);

  p_en_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wen0 |=> e0 == $past(pwdata));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr0 |=> (($past(p0 & m0) & m0 & ~p0) == 32'd0));

  p_status_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == ADDR_W'('h14)) |-> prdata == (p0 & e0));

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && int'(paddr) > LAST) |-> prdata == 32'd0);
endmodule

bind dual_route_intc dri_chk #(
  .NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .LAST(LAST_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .pend_flat(pend_flat), .en_flat(en_flat), .mode_flat(mode_flat)
);

// File: tb/dual_route_intc_test.sv
module dual_route_intc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src = '0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o, fiq_o;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  dual_route_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [11:0] base(input int s);
    return 12'((s / 2) * 'h60 + (s % 2) * 'h20);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #2 d = prdata;
    psel = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    src = '0;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 irq during reset", {31'd0, irq_o}, 0);
    chk("R1 fiq during reset", {31'd0, fiq_o}, 0);
    rst_n = 1;
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 6; o++) begin
        rd(base(s) + 12'(o * 4), v);
        chk("R1 reg zero after reset", v, 0);
      end

    // R3 readback of enable/mode/polarity in all sets
    for (int s = 0; s < 4; s++) begin
      wr(base(s) + 12'h04, 32'hA5C3_0F00 + s);
      wr(base(s) + 12'h0C, 32'h1234_5678 ^ s);
      wr(base(s) + 12'h10, 32'h0F0F_8001 + s);
    end
    for (int s = 0; s < 4; s++) begin
      rd(base(s) + 12'h04, v); chk("R3 enable readback", v, 32'hA5C3_0F00 + s);
      rd(base(s) + 12'h0C, v); chk("R3 mode readback", v, 32'h1234_5678 ^ s);
      rd(base(s) + 12'h10, v); chk("R3 polarity readback", v, 32'h0F0F_8001 + s);
      rd(base(s) + 12'h08, v); chk("R2 clear word reads zero", v, 0);
    end

    // R9 out-of-range
    do_reset();
    wr(12'h0A4, 32'hFFFF_FFFF);
    wr(12'h098, 32'hFFFF_FFFF);
    rd(12'h0A4, v); chk("R9 oob read", v, 0);
    rd(12'h098, v); chk("R9 oob read 0x98", v, 0);
    rd(12'h084, v); chk("R9 oob write ignored", v, 0);
    rd(12'h004, v); chk("R9 oob write ignored set0", v, 0);

    // R2 pending word is read-only
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R2 pending read-only", v, 0);

    // R4/R8 one-hot level-high sweep over all 64 lines on the normal route
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h064, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      src = 64'd1 << i;
      settle();
      rd(12'h014, v); chk("R4 sweep bank0 status", v, i < 32 ? (32'd1 << i) : 32'd0);
      rd(12'h074, v); chk("R4 sweep bank1 status", v, i >= 32 ? (32'd1 << (i - 32)) : 32'd0);
      chk("R8 irq high in sweep", {31'd0, irq_o}, 1);
      chk("R8 fiq low in sweep", {31'd0, fiq_o}, 0);
      src = '0;
      settle();
      chk("R4 irq drops with line", {31'd0, irq_o}, 0);
    end

    // R10 latency
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R10 no output after two edges", {31'd0, irq_o}, 0);
    @(negedge clk); chk("R10 output at third edge", {31'd0, irq_o}, 1);

    // R4 active-low on fast route bank0
    do_reset();
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFFFF_FFFF);
    settle();
    rd(12'h020, v); chk("R4 active-low pending", v, 32'hFFFF_FFFF);
    chk("R8 fiq from active-low", {31'd0, fiq_o}, 1);
    chk("R8 irq not routed", {31'd0, irq_o}, 0);
    src[31:0] = 32'hFFFF_FFFF;
    settle();
    rd(12'h020, v); chk("R4 active-low released", v, 0);
    chk("R4 fiq low", {31'd0, fiq_o}, 0);

    // R5/R6 rising edge on source 37 (bank1 bit 5)
    do_reset();
    wr(12'h06C, 32'h0000_0020);
    wr(12'h064, 32'h0000_0024);
    src[37] = 1; settle(); src[37] = 0; settle();
    rd(12'h060, v); chk("R5 rising edge latched", v, 32'h20);
    chk("R8 irq from bank1 edge", {31'd0, irq_o}, 1);
    src[34] = 1; settle(); // level-mode bit 2 of bank1 held high
    wr(12'h068, 32'hFFFF_FFFF);
    settle();
    rd(12'h060, v); chk("R6 clear leaves level bit only", v, 32'h04);

    // R5 falling edge on fast route bank0 bit 3
    do_reset();
    wr(12'h02C, 32'h8);
    wr(12'h030, 32'h8);
    wr(12'h024, 32'h8);
    src[3] = 1; settle();
    rd(12'h020, v); chk("R5 no event on rise when falling selected", v, 0);
    src[3] = 0; settle();
    rd(12'h020, v); chk("R5 falling edge latched", v, 32'h8);
    chk("R5 fiq high", {31'd0, fiq_o}, 1);

    // R8 one source on both routes with different modes
    do_reset();
    wr(12'h004, 32'h400);
    wr(12'h024, 32'h400);
    wr(12'h02C, 32'h400);
    src[10] = 1; settle(); src[10] = 0; settle();
    chk("R8 irq level route low", {31'd0, irq_o}, 0);
    chk("R8 fiq edge route held", {31'd0, fiq_o}, 1);

    // R7 masked status
    do_reset();
    src[0] = 1; settle();
    rd(12'h000, v); chk("R7 pending set", v, 1);
    rd(12'h014, v); chk("R7 status masked", v, 0);
    chk("R7 irq masked", {31'd0, irq_o}, 0);
    wr(12'h004, 32'h1);
    rd(12'h014, v); chk("R7 status unmasked", v, 1);

    // R11 edge event and clear in the same cycle
    do_reset();
    wr(12'h00C, 32'h2);
    src[1] = 1; settle(); src[1] = 0; settle();
    rd(12'h000, v); chk("R11 precondition", v, 2);
    @(negedge clk); src[1] = 1;
    wr(12'h008, 32'h2);
    settle();
    rd(12'h000, v); chk("R11 set wins over clear", v, 2);
    wr(12'h008, 32'h2);
    rd(12'h000, v); chk("R6 clear alone", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule